// File: doc/BRIEF.md
# Golden Nonce Report Buffer

This block gathers the nonces that the hash array finds for the work in progress. It lays them out as a fixed 736-bit report: 21 nonce slots of 32 bits each, followed by the 64-bit identifier of the work. Every slot that no nonce has claimed holds a filler word, and the host skips it. Each stored nonce is biased by a fixed offset, and the host removes that offset.

The report is held in two register levels. The collection level fills while the hash array runs. The presentation level holds the report that the serial interface is shifting out. A frame-swap pulse from the serial interface copies the collection level into the presentation level and clears the collection level. A work ID loaded by a work-start pulse therefore appears at the output one swap later. Because the work itself is also sent one frame before its hashing begins, the report leaves the chip two frames after the work came in.

The collection level is run by a three-state machine:
- **EMPTY**: no slot is used.
- **FILLING**: some slots are used.
- **FULL**: all 21 slots are used.

Its transitions are:
- **first_hit**: EMPTY to FILLING, on a nonce strobe.
- **last_slot**: FILLING to FULL, when the strobe lands in slot 20.
- **swap_clear**: any state to EMPTY, on a swap with no strobe.
- **swap_hit**: any state to FILLING, on a swap together with a strobe.

A strobe that arrives in FULL is dropped and sets the overflow flag.

Top module: `nonce_report_buffer`

## Requirements
- R1: After reset, every nonce slot of `report` holds 0xBEAFBEAF, the work ID field is zero, and `overflow` is low.
- R2: A nonce accepted into a slot is stored as the strobed value plus 0x4000, modulo 2^32.
- R3: Slot k (k = 0..20) occupies `report[735-32k -: 32]`, and the work ID occupies `report[63:0]`. The first nonce found since the last swap goes to slot 0, and later ones follow in order of arrival.
- R4: Every slot that received no nonce during the collection reads 0xBEAFBEAF in the report.
- R5: `report` changes only on the clock edge that samples `frame_swap` high. It then shows the collection gathered since the previous swap, and it stays constant between swaps.
- R6: `work_start` loads `work_id` into the collection level. That ID appears in `report` after the next swap and is kept across later swaps until a new `work_start` arrives.
- R7: A nonce strobe that arrives when all 21 slots are used is dropped and sets `overflow`. `overflow` stays high until the next swap clears it.
- R8: A nonce strobe in the same cycle as `frame_swap` goes into slot 0 of the new collection, not into the report being swapped out.
- R9: A `work_start` in the same cycle as `frame_swap` sends the old ID out with the swapped report and gives the new ID to the new collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nonce_vld | input | 1 | Found-nonce strobe |
| nonce_val | input | 32 | Found nonce value |
| work_start | input | 1 | Start of a new work, loads the ID |
| work_id | input | 64 | Identifier of the new work |
| frame_swap | input | 1 | Frame boundary from the serial interface |
| report | output | 736 | Report frame, slot 0 in the top bits |
| overflow | output | 1 | Sticky flag: collection dropped a nonce |

## Verification
Directed frames are used to separate the following cases:
- An empty collection and a collection with three nonces, which tells filler placement apart from slot order.
- A nonce near 2^32, which shows that the offset wraps.
- A burst of 25 nonces, which checks the drop and overflow behaviour at the slot limit.
- A swap that coincides with a nonce strobe or with a work start, which tells the old collection apart from the new one.

Several thousand cycles of seeded random strobes, swaps and work starts then compare the whole report and the overflow flag each cycle against a bench model. Frame lengths vary, so this covers every slot count from zero to overflow.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ID_W   = 64;
    localparam logic [WORD_W-1:0] FILLER_WORD = 32'hBEAF_BEAF;
    localparam logic [WORD_W-1:0] NONCE_BIAS  = 32'h0000_4000;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } coll_state_e;
endpackage

// File: rtl/nrb_collect.sv
module nrb_collect
    import nrb_pkg::*;
#(
    parameter int unsigned NSLOT = 21,
    localparam int unsigned FRAME_W = NSLOT * WORD_W + ID_W,
    localparam int unsigned CNT_W = $clog2(NSLOT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nonce_vld,
    input  logic [WORD_W-1:0]  nonce_val,
    input  logic               work_start,
    input  logic [ID_W-1:0]    work_id,
    input  logic               swap,
    output logic [FRAME_W-1:0] frame,
    output logic               overflow
);
    localparam coll_state_e ST_AFTER_ONE = (NSLOT == 1) ? ST_FULL : ST_FILLING;

    coll_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_q;
    logic [ID_W-1:0]    id_q;
    logic [WORD_W-1:0]  slot_q [NSLOT];
    logic               wr_en;
    logic [CNT_W-1:0]   wr_idx;
    logic [WORD_W-1:0]  biased;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (nonce_vld) state_d = ST_AFTER_ONE;
            end
            ST_FILLING: begin
                if (swap)
                    state_d = nonce_vld ? ST_AFTER_ONE : ST_EMPTY;
                else if (nonce_vld && cnt_q == CNT_W'(NSLOT - 1))
                    state_d = ST_FULL;
            end
            ST_FULL: begin
                if (swap) state_d = nonce_vld ? ST_AFTER_ONE : ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs of the machine: slot write control
    always_comb begin
        wr_en  = nonce_vld && (swap || state_q != ST_FULL);
        wr_idx = swap ? '0 : cnt_q;
        biased = nonce_val + NONCE_BIAS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            id_q  <= '0;
        end else begin
            if (swap) begin
                cnt_q <= nonce_vld ? CNT_W'(1) : '0;
                ovf_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(wr_en);
                ovf_q <= ovf_q | (nonce_vld && state_q == ST_FULL);
            end
            if (work_start) id_q <= work_id;
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                          slot_q[i] <= FILLER_WORD;
            else if (wr_en && wr_idx == CNT_W'(i)) slot_q[i] <= biased;
            else if (swap)                       slot_q[i] <= FILLER_WORD;
        end
        assign frame[FRAME_W-1-i*WORD_W -: WORD_W] = slot_q[i];
    end
    assign frame[ID_W-1:0] = id_q;
    assign overflow = ovf_q;

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(state_q == ST_FULL && nonce_vld && !swap));
    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> !ovf_q);
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NSLOT));
    assert_empty_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (cnt_q == '0));
    assert_swap_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && nonce_vld) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/nrb_hold.sv
module nrb_hold
    import nrb_pkg::*;
#(
    parameter int unsigned NSLOT = 21,
    localparam int unsigned FRAME_W = NSLOT * WORD_W + ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swap,
    input  logic [FRAME_W-1:0] frame_in,
    output logic [FRAME_W-1:0] frame_out
);
    localparam logic [FRAME_W-1:0] RESET_FRAME = {{NSLOT{FILLER_WORD}}, {ID_W{1'b0}}};

    logic [FRAME_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    frame_q <= RESET_FRAME;
        else if (swap) frame_q <= frame_in;
    end
    assign frame_out = frame_q;

    assert_report_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(frame_q));
    assert_report_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (frame_q == $past(frame_in)));
endmodule

// File: rtl/nonce_report_buffer.sv
module nonce_report_buffer
    import nrb_pkg::*;
#(
    parameter int unsigned NSLOT = 21,
    localparam int unsigned FRAME_W = NSLOT * WORD_W + ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nonce_vld,
    input  logic [31:0]        nonce_val,
    input  logic               work_start,
    input  logic [63:0]        work_id,
    input  logic               frame_swap,
    output logic [FRAME_W-1:0] report,
    output logic               overflow
);
    logic [FRAME_W-1:0] coll_frame;

    nrb_collect #(.NSLOT(NSLOT)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .nonce_vld  (nonce_vld),
        .nonce_val  (nonce_val),
        .work_start (work_start),
        .work_id    (work_id),
        .swap       (frame_swap),
        .frame      (coll_frame),
        .overflow   (overflow)
    );

    nrb_hold #(.NSLOT(NSLOT)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (frame_swap),
        .frame_in  (coll_frame),
        .frame_out (report)
    );

    assert_id_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_swap && work_start) |=> (report[ID_W-1:0] != $past(work_id)
                                        || coll_frame[ID_W-1:0] == $past(work_id)));
endmodule

// File: tb/nonce_report_buffer_tb.sv
module nonce_report_buffer_tb;
    localparam int NS = 21;
    localparam int RW = NS * 32 + 64;
    localparam logic [31:0] FILL = 32'hBEAF_BEAF;
    localparam logic [31:0] BIAS = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nonce_vld = 1'b0;
    logic [31:0] nonce_val = '0;
    logic work_start = 1'b0;
    logic [63:0] work_id = '0;
    logic frame_swap = 1'b0;
    logic [RW-1:0] report;
    logic overflow;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_c [NS];
    int          m_cnt;
    logic        m_ovf;
    logic [63:0] m_cid;
    logic [RW-1:0] m_out;

    always #10 clk = ~clk;

    nonce_report_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .nonce_vld(nonce_vld), .nonce_val(nonce_val),
        .work_start(work_start), .work_id(work_id), .frame_swap(frame_swap),
        .report(report), .overflow(overflow)
    );

    function automatic logic [RW-1:0] pack_frame();
        logic [RW-1:0] f;
        for (int i = 0; i < NS; i++) f[RW-1-i*32 -: 32] = m_c[i];
        f[63:0] = m_cid;
        return f;
    endfunction

    function automatic logic [31:0] slot_of(input logic [RW-1:0] r, input int k);
        return r[RW-1-k*32 -: 32];
    endfunction

    task automatic clear_coll();
        for (int i = 0; i < NS; i++) m_c[i] = FILL;
        m_cnt = 0;
        m_ovf = 1'b0;
    endtask

    task automatic model_edge(input logic nv, input logic [31:0] nval,
                              input logic ws, input logic [63:0] wid, input logic sw);
        if (sw) begin
            m_out = pack_frame();
            clear_coll();
        end
        if (ws) m_cid = wid;
        if (nv) begin
            if (m_cnt < NS) begin
                m_c[m_cnt] = nval + BIAS;
                m_cnt++;
            end else begin
                m_ovf = 1'b1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic nv, input logic [31:0] nval,
                        input logic ws, input logic [63:0] wid, input logic sw);
        nonce_vld = nv; nonce_val = nval; work_start = ws; work_id = wid; frame_swap = sw;
        @(posedge clk);
        model_edge(nv, nval, ws, wid, sw);
        @(negedge clk);
        nonce_vld = 1'b0; work_start = 1'b0; frame_swap = 1'b0;
    endtask

    task automatic cmp_all(input string tag);
        chk({tag, " report (R5)"}, report, m_out);
        chk({tag, " overflow (R7)"}, RW'(overflow), RW'(m_ovf));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_coll();
        m_cid = '0;
        m_out = {{NS{FILL}}, 64'd0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 reset report", report, {{NS{FILL}}, 64'd0});
        chk("R1 reset overflow", RW'(overflow), '0);

        // R4: empty collection swapped out stays all filler
        step(1'b0, 0, 1'b0, 0, 1'b1);
        chk("R4 empty frame", report, {{NS{FILL}}, 64'd0});

        // R2 R3 R6: three nonces, one wraps
        step(1'b0, 0, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0);
        step(1'b1, 32'h0000_0010, 1'b0, 0, 1'b0);
        step(1'b1, 32'hFFFF_F000, 1'b0, 0, 1'b0);
        step(1'b1, 32'h1234_5678, 1'b0, 0, 1'b0);
        chk("R5 no change before swap", report, {{NS{FILL}}, 64'd0});
        step(1'b0, 0, 1'b0, 0, 1'b1);
        chk("R2 slot0 biased", RW'(slot_of(report, 0)), RW'(32'h0000_4010));
        chk("R2 wrap slot1", RW'(slot_of(report, 1)), RW'(32'h0000_3000));
        chk("R3 slot2 order", RW'(slot_of(report, 2)), RW'(32'h1234_9678));
        chk("R4 slot3 filler", RW'(slot_of(report, 3)), RW'(FILL));
        chk("R4 slot20 filler", RW'(slot_of(report, 20)), RW'(FILL));
        chk("R6 work id field", RW'(report[63:0]), RW'(64'h0123_4567_89AB_CDEF));
        cmp_all("R3 whole");

        // R6: ID kept across a swap with no work_start
        step(1'b0, 0, 1'b0, 0, 1'b1);
        chk("R6 id kept", RW'(report[63:0]), RW'(64'h0123_4567_89AB_CDEF));

        // R7: overflow
        for (int i = 0; i < 25; i++) begin
            step(1'b1, 32'(i * 3 + 1), 1'b0, 0, 1'b0);
            if (i == 20) chk("R7 no ovf at 21", RW'(overflow), '0);
            if (i == 21) chk("R7 ovf at 22", RW'(overflow), RW'(1'b1));
        end
        step(1'b0, 0, 1'b0, 0, 1'b0);
        chk("R7 ovf sticky", RW'(overflow), RW'(1'b1));
        step(1'b0, 0, 1'b0, 0, 1'b1);
        chk("R7 ovf cleared by swap", RW'(overflow), '0);
        chk("R7 last kept slot", RW'(slot_of(report, 20)), RW'(32'(20 * 3 + 1) + BIAS));
        cmp_all("R7 frame");

        // R8 R9: strobe and work start coincide with swap
        step(1'b1, 32'hAAAA_0000, 1'b0, 0, 1'b0);
        step(1'b1, 32'h5555_0000, 1'b1, 64'hFEED_0000_0000_0001, 1'b1);
        chk("R8 old frame slot0", RW'(slot_of(report, 0)), RW'(32'hAAAA_4000));
        chk("R8 old frame slot1", RW'(slot_of(report, 1)), RW'(FILL));
        chk("R9 old id out", RW'(report[63:0]), RW'(64'h0123_4567_89AB_CDEF));
        step(1'b0, 0, 1'b0, 0, 1'b1);
        chk("R8 new frame slot0", RW'(slot_of(report, 0)), RW'(32'h5555_4000));
        chk("R9 new id", RW'(report[63:0]), RW'(64'hFEED_0000_0000_0001));
        cmp_all("R8 frame");

        // random phase
        for (int c = 0; c < 6000; c++) begin
            automatic int frame_len = ($urandom % 4 == 0) ? 40 : 12;
            automatic logic sw = ($urandom % frame_len) == 0;
            automatic logic nv = ($urandom % 3) != 0;
            automatic logic ws = ($urandom % 37) == 0;
            step(nv, $urandom, ws, {$urandom, $urandom}, sw);
            cmp_all("R5 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule